// File: doc/BRIEF.md
# Dual-Mode Pixel Photon Counter and Time-to-Digital Converter

This block sits behind one detector in a line of pixels that all acquire at the same moment under a global frame. For each frame it runs in one of two modes, chosen when the frame opens. In counting mode its 6-bit counter tallies detector pulses. In timing mode the same counter becomes the coarse stage of a time-to-digital converter. The counter starts on the first detector pulse of the frame and counts reference-clock periods until a stop pulse arrives. The stop pulse is common to every pixel.

The sub-period position of each event arrives as a 16-phase thermometer sample. The sample for the detector event is produced locally. The sample for the stop pulse comes from a shared interpolator. Each sample is decoded to a 4-bit fine code. The fine codes are merged with the coarse count into a 10-bit time word. Because start and stop are unrelated to the reference clock, repeated conversions of one interval land on different coarse/fine splits, which averages out converter nonlinearity.

One result word is reported per frame, one cycle after the frame closes. A flag marks whether the frame held an event. A second flag marks overflow.

Top module: `px_tdc_top`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_word`, `out_hit` and `out_ovf` are all zero.
- R2: `frame_start` opens a frame, clears all per-frame state and latches `mode_time` (0 = counting, 1 = timing). `frame_end` in an open frame closes it. `out_valid` is then high for exactly the one cycle after that edge. The result outputs hold their value until the next report.
- R3: In counting mode, each cycle with `det_pulse` high inside an open frame adds one to the count. Cycles in which `frame_start` or `frame_end` is high are not counted. The report has `out_word` equal to the count zero-extended to 10 bits, `out_hit`=1 and `out_ovf`=0.
- R4: In counting mode a pulse that arrives while the count is already 63 sets overflow. The report is then `out_word`=1023 and `out_ovf`=1. Exactly 63 pulses give 63 with no overflow.
- R5: A phase sample decodes to the length of the unbroken run of ones starting at bit 0, clamped to 15. Any ones above the first zero (a bubble) are ignored.
- R6: In timing mode, the first detector pulse of the frame starts the conversion at edge E0 and latches its fine code. A stop at edge Ek (k ≥ 1) latches the stop fine code. The report is `out_word` = 16·k + fine_start − fine_stop, with `out_hit`=1 and `out_ovf`=0. The subtraction borrows from the coarse part.
- R7: In timing mode, detector pulses after the first start are ignored. So are stop pulses before the start, in the start cycle, or after the first accepted stop.
- R8: In timing mode, if the coarse count is 63 and no stop has yet arrived, the conversion overflows. This covers a stop at k = 64 and later. The same applies to a frame that closes while the conversion is still running. Either case reports `out_word`=1023, `out_hit`=1 and `out_ovf`=1. A stop at k = 63 is still converted normally.
- R9: A timing-mode frame with no detector pulse reports `out_hit`=0, `out_word`=0 and `out_ovf`=0.
- R10: Detector and stop pulses outside an open frame have no effect. A `frame_end` with no open frame produces no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Opens a frame, one-cycle strobe |
| frame_end | input | 1 | Closes the frame, one-cycle strobe |
| mode_time | input | 1 | Mode for the next frame: 0 counting, 1 timing |
| det_pulse | input | 1 | Synchronised detector event strobe |
| det_phase | input | 16 | Thermometer phase sample taken at the detector event |
| stop_pulse | input | 1 | Common stop strobe |
| stop_phase | input | 16 | Thermometer phase sample of the stop from the shared interpolator |
| out_valid | output | 1 | One-cycle report strobe |
| out_word | output | 10 | Count or time word |
| out_hit | output | 1 | Frame held a counted frame or a start event |
| out_ovf | output | 1 | Overflow or missing stop |

## Verification
The bench builds the block with its default parameters: a 6-bit counter and 16 phases. With these values both overflow limits can be reached within frames of about seventy cycles. The bench therefore drives the exact 63/64 boundaries in both modes, and it drives a borrow case where the stop's fine code exceeds the start's. It also feeds thermometer samples with bubbles and an all-ones sample, which exercise the decode clamp.

// File: rtl/px_tdc_pkg.sv
package px_tdc_pkg;
  typedef enum logic {
    PX_COUNT = 1'b0,
    PX_TIME  = 1'b1
  } px_mode_e;
endpackage

// File: rtl/px_therm_dec.sv
module px_therm_dec #(
  parameter int PHASES = 16,
  parameter int FINE_W = $clog2(PHASES)
) (
  input  logic [PHASES-1:0] therm,
  output logic [FINE_W-1:0] code
);
  logic [PHASES-1:0] run;
  int                n;

  assign run[0] = therm[0];
  for (genvar i = 1; i < PHASES; i++) begin : g_run
    assign run[i] = run[i-1] & therm[i];
  end

  always_comb begin
    n = 0;
    for (int j = 0; j < PHASES; j++) n += int'(run[j]);
    if (n > PHASES - 1) n = PHASES - 1;
    code = FINE_W'(n);
  end
endmodule

// File: rtl/px_frame_core.sv
module px_frame_core
  import px_tdc_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              mode_time,
  input  logic              det_pulse,
  input  logic              stop_pulse,
  input  logic [FINE_W-1:0] det_fine,
  input  logic [FINE_W-1:0] stop_fine,
  output logic              active,
  output px_mode_e          mode_q,
  output logic              started,
  output logic              stopped,
  output logic              ovf,
  output logic [CNT_W-1:0]  cnt,
  output logic [FINE_W-1:0] fine_start,
  output logic [FINE_W-1:0] fine_stop
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic open_cycle, cnt_evt, start_evt, run_evt;

  assign open_cycle = active && !frame_start && !frame_end;
  assign cnt_evt    = open_cycle && (mode_q == PX_COUNT) && det_pulse;
  assign start_evt  = open_cycle && (mode_q == PX_TIME) && !started && det_pulse;
  assign run_evt    = open_cycle && (mode_q == PX_TIME) && started && !stopped && !ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      mode_q     <= PX_COUNT;
      started    <= 1'b0;
      stopped    <= 1'b0;
      ovf        <= 1'b0;
      cnt        <= '0;
      fine_start <= '0;
      fine_stop  <= '0;
    end else if (frame_start) begin
      active     <= 1'b1;
      mode_q     <= px_mode_e'(mode_time);
      started    <= 1'b0;
      stopped    <= 1'b0;
      ovf        <= 1'b0;
      cnt        <= '0;
      fine_start <= '0;
      fine_stop  <= '0;
    end else if (frame_end) begin
      active <= 1'b0;
    end else begin
      if (cnt_evt) begin
        if (cnt == CNT_MAX) ovf <= 1'b1;
        else                cnt <= cnt + 1'b1;
      end
      if (start_evt) begin
        started    <= 1'b1;
        cnt        <= '0;
        fine_start <= det_fine;
      end
      if (run_evt) begin
        if (cnt == CNT_MAX) begin
          ovf <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (stop_pulse) begin
            stopped   <= 1'b1;
            fine_stop <= stop_fine;
          end
        end
      end
    end
  end
endmodule

// File: rtl/px_word_fmt.sv
module px_word_fmt
  import px_tdc_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FINE_W = 4,
  parameter int OUT_W  = CNT_W + FINE_W
) (
  input  px_mode_e          mode_q,
  input  logic              started,
  input  logic              stopped,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [FINE_W-1:0] fine_start,
  input  logic [FINE_W-1:0] fine_stop,
  output logic [OUT_W-1:0]  word,
  output logic              hit,
  output logic              ovf_out
);
  function automatic logic [OUT_W-1:0] time_word(
    input logic [CNT_W-1:0] c, input logic [FINE_W-1:0] fs, input logic [FINE_W-1:0] fp);
    logic [OUT_W-1:0] w;
    w = {c, {FINE_W{1'b0}}} + OUT_W'(fs) - OUT_W'(fp);
    return w;
  endfunction

  always_comb begin
    if (mode_q == PX_COUNT) begin
      hit     = 1'b1;
      ovf_out = ovf;
      word    = ovf ? '1 : {{FINE_W{1'b0}}, cnt};
    end else if (!started) begin
      hit     = 1'b0;
      ovf_out = 1'b0;
      word    = '0;
    end else if (ovf || !stopped) begin
      hit     = 1'b1;
      ovf_out = 1'b1;
      word    = '1;
    end else begin
      hit     = 1'b1;
      ovf_out = 1'b0;
      word    = time_word(cnt, fine_start, fine_stop);
    end
  end
endmodule

// File: rtl/px_tdc_top.sv
module px_tdc_top
  import px_tdc_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int PHASES = 16,
  parameter int FINE_W = $clog2(PHASES),
  parameter int OUT_W  = CNT_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              mode_time,
  input  logic              det_pulse,
  input  logic [PHASES-1:0] det_phase,
  input  logic              stop_pulse,
  input  logic [PHASES-1:0] stop_phase,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_word,
  output logic              out_hit,
  output logic              out_ovf
);
  logic [FINE_W-1:0] det_fine, stop_fine, fine_start, fine_stop;
  logic              core_active, core_started, core_stopped, core_ovf;
  px_mode_e          core_mode;
  logic [CNT_W-1:0]  core_cnt;
  logic [OUT_W-1:0]  fmt_word;
  logic              fmt_hit, fmt_ovf, report_evt;

  px_therm_dec #(.PHASES(PHASES), .FINE_W(FINE_W)) u_dec_det (
    .therm(det_phase), .code(det_fine));
  px_therm_dec #(.PHASES(PHASES), .FINE_W(FINE_W)) u_dec_stop (
    .therm(stop_phase), .code(stop_fine));

  px_frame_core #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .mode_time(mode_time), .det_pulse(det_pulse), .stop_pulse(stop_pulse),
    .det_fine(det_fine), .stop_fine(stop_fine), .active(core_active),
    .mode_q(core_mode), .started(core_started), .stopped(core_stopped),
    .ovf(core_ovf), .cnt(core_cnt), .fine_start(fine_start), .fine_stop(fine_stop));

  px_word_fmt #(.CNT_W(CNT_W), .FINE_W(FINE_W), .OUT_W(OUT_W)) u_fmt (
    .mode_q(core_mode), .started(core_started), .stopped(core_stopped),
    .ovf(core_ovf), .cnt(core_cnt), .fine_start(fine_start), .fine_stop(fine_stop),
    .word(fmt_word), .hit(fmt_hit), .ovf_out(fmt_ovf));

  assign report_evt = core_active && frame_end && !frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_hit   <= 1'b0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= report_evt;
      if (report_evt) begin
        out_word <= fmt_word;
        out_hit  <= fmt_hit;
        out_ovf  <= fmt_ovf;
      end
    end
  end
endmodule

// File: rtl/px_tdc_chk.sv
module px_tdc_chk #(
  parameter int CNT_W = 6,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             frame_end,
  input logic             active,
  input logic             started,
  input logic             stopped,
  input logic [CNT_W-1:0] cnt,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_word,
  input logic             out_hit,
  input logic             out_ovf
);
  // R2
  end_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && frame_end && !frame_start) |=> out_valid);
  // R2
  report_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(frame_end));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_word) && $stable(out_hit) && $stable(out_ovf)));
  // R4
  ovf_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_word == '1));
  // R9
  no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_word == '0 && !out_ovf));
  // R7
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !frame_start) |=> started);
  // R7
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !frame_start) |=> $stable(cnt));
endmodule

bind px_tdc_top px_tdc_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_px_tdc_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
  .active(core_active), .started(core_started), .stopped(core_stopped),
  .cnt(core_cnt), .out_valid(out_valid), .out_word(out_word),
  .out_hit(out_hit), .out_ovf(out_ovf));

// File: tb/test_px_tdc_top.sv
module test_px_tdc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, frame_end = 1'b0, mode_time = 1'b0;
  logic        det_pulse = 1'b0, stop_pulse = 1'b0;
  logic [15:0] det_phase = '0, stop_phase = '0;
  logic        out_valid, out_hit, out_ovf;
  logic [9:0]  out_word;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  px_tdc_top i_px_tdc_top (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .mode_time(mode_time), .det_pulse(det_pulse), .det_phase(det_phase),
    .stop_pulse(stop_pulse), .stop_phase(stop_phase), .out_valid(out_valid),
    .out_word(out_word), .out_hit(out_hit), .out_ovf(out_ovf));

  // behavioural reference model
  int m_open = 0, m_time = 0, m_go = 0, m_halt = 0, m_over = 0, m_n = 0, m_fs = 0, m_fp = 0;
  int e_valid = 0, e_word = 0, e_hit = 0, e_ovf = 0;

  function automatic int run_len(input logic [15:0] ph);
    int k = 0;
    while (k < 16 && ph[k] == 1'b1) k++;
    return (k == 16) ? 15 : k;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_open = 0; m_go = 0; m_halt = 0; m_over = 0; m_n = 0;
      e_valid = 0; e_word = 0; e_hit = 0; e_ovf = 0;
    end else begin
      e_valid = 0;
      if (frame_start) begin
        m_open = 1; m_time = int'(mode_time); m_go = 0; m_halt = 0; m_over = 0;
        m_n = 0; m_fs = 0; m_fp = 0;
      end else if (frame_end) begin
        if (m_open == 1) begin
          e_valid = 1;
          if (m_time == 0) begin
            e_hit = 1; e_ovf = m_over; e_word = m_over ? 1023 : m_n;
          end else if (m_go == 0) begin
            e_hit = 0; e_ovf = 0; e_word = 0;
          end else if (m_over == 1 || m_halt == 0) begin
            e_hit = 1; e_ovf = 1; e_word = 1023;
          end else begin
            e_hit = 1; e_ovf = 0; e_word = m_n * 16 + m_fs - m_fp;
          end
        end
        m_open = 0;
      end else if (m_open == 1) begin
        if (m_time == 0) begin
          if (det_pulse) begin
            if (m_n == 63) m_over = 1; else m_n++;
          end
        end else if (m_go == 0) begin
          if (det_pulse) begin m_go = 1; m_n = 0; m_fs = run_len(det_phase); end
        end else if (m_halt == 0 && m_over == 0) begin
          if (m_n == 63) m_over = 1;
          else begin
            m_n++;
            if (stop_pulse) begin m_halt = 1; m_fp = run_len(stop_phase); end
          end
        end
      end
    end
  end

  // per-cycle comparison against the model (R2 timing of every output)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (int'(out_valid) != e_valid || int'(out_word) != e_word ||
          int'(out_hit) != e_hit || int'(out_ovf) != e_ovf) begin
        mismatched++;
        $display("FAIL R2 cycle %0d: got v=%0d w=%0d h=%0d o=%0d exp v=%0d w=%0d h=%0d o=%0d",
                 cycles, out_valid, out_word, out_hit, out_ovf, e_valid, e_word, e_hit, e_ovf);
      end
    end
  end

  task automatic check(input string tag, input int v, input int w, input int h, input int o);
    compared++;
    if (int'(out_valid) != v || int'(out_word) != w || int'(out_hit) != h || int'(out_ovf) != o) begin
      mismatched++;
      $display("FAIL %s: got v=%0d w=%0d h=%0d o=%0d exp v=%0d w=%0d h=%0d o=%0d",
               tag, out_valid, out_word, out_hit, out_ovf, v, w, h, o);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic open_frame(input logic m);
    frame_start = 1'b1; mode_time = m; @(negedge clk); frame_start = 1'b0;
  endtask
  task automatic close_frame();
    frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
  endtask
  task automatic det(input logic [15:0] ph);
    det_pulse = 1'b1; det_phase = ph; @(negedge clk); det_pulse = 1'b0; det_phase = '0;
  endtask
  task automatic stp(input logic [15:0] ph);
    stop_pulse = 1'b1; stop_phase = ph; @(negedge clk); stop_pulse = 1'b0; stop_phase = '0;
  endtask
  task automatic timed(input int k, input logic [15:0] fs, input logic [15:0] fp);
    open_frame(1'b1); idle(2); det(fs); idle(k - 1); stp(fp); idle(1); close_frame();
  endtask

  initial begin
    idle(3);
    check("R1 reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    idle(2);

    // R10: activity with no open frame, then stray frame_end
    det(16'h00FF); stp(16'h0001); close_frame();
    check("R10 no report without frame", 0, 0, 0, 0);

    // R3: five gapped pulses; pulses in the open and close cycles ignored
    det_pulse = 1'b1; open_frame(1'b0); det_pulse = 1'b0;
    for (int i = 0; i < 5; i++) begin det(16'h0000); idle(2); end
    det_pulse = 1'b1; close_frame(); det_pulse = 1'b0;
    check("R3 count five", 1, 5, 1, 0);
    idle(1);
    check("R2 valid one cycle, word held", 0, 5, 1, 0);

    // R4: 63 pulses no overflow, 64 pulses overflow
    open_frame(1'b0); det_pulse = 1'b1; idle(63); det_pulse = 1'b0; close_frame();
    check("R4 count 63", 1, 63, 1, 0);
    open_frame(1'b0); det_pulse = 1'b1; idle(64); det_pulse = 1'b0; close_frame();
    check("R4 count 64 overflow", 1, 1023, 1, 1);
    open_frame(1'b0); det_pulse = 1'b1; idle(70); det_pulse = 1'b0; close_frame();
    check("R4 count 70 overflow", 1, 1023, 1, 1);

    // R6 with R5 thermometer codes 7 and 3
    timed(10, 16'h007F, 16'h0007);
    check("R6 k10 7-3", 1, 10 * 16 + 7 - 3, 1, 0);

    // R5 bubble (run of 3) and all-ones clamp (15)
    timed(4, 16'b0000_0000_1101_0111, 16'hFFFF);
    check("R5 bubble and clamp", 1, 4 * 16 + 3 - 15, 1, 0);

    // R6 borrow: k1, fine 0 - 15
    timed(1, 16'h0000, 16'hFFFF);
    check("R6 borrow k1", 1, 1, 1, 0);

    // R7: early stop, second det, second stop ignored
    open_frame(1'b1); stp(16'h00FF); det(16'h001F); det(16'hFFFF);
    stp(16'h0000); stp(16'h3FFF); idle(3); close_frame();
    check("R7 extra pulses ignored", 1, 2 * 16 + 5 - 0, 1, 0);

    // R8: boundary k63 converts, k64 overflows
    timed(63, 16'h000F, 16'h0003);
    check("R8 k63 converts", 1, 63 * 16 + 4 - 2, 1, 0);
    timed(64, 16'h000F, 16'h0003);
    check("R8 k64 overflow", 1, 1023, 1, 1);

    // R8: no stop, frame closes while running
    open_frame(1'b1); det(16'h0001); idle(5); close_frame();
    check("R8 frame ends running", 1, 1023, 1, 1);
    open_frame(1'b1); det(16'h0001); idle(80); close_frame();
    check("R8 no stop long frame", 1, 1023, 1, 1);

    // R9: timing frame with no detector pulse
    open_frame(1'b1); stp(16'h00FF); idle(4); close_frame();
    check("R9 no hit", 1, 0, 0, 0);

    // R2: mode latched at open; changing mode_time mid-frame has no effect
    open_frame(1'b0); mode_time = 1'b1; det(16'h0000); det(16'h0000); close_frame();
    check("R2 mode latched", 1, 2, 1, 0);

    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: got cycles=%0d exp completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule